// File: doc/BRIEF.md
# Board configuration transaction controller

This block is a small register-mapped controller that lets software query and program board configuration resources through a single command word. Software places an operand in a data register, then writes a control word whose top bit launches one transaction. The remaining fields of that word route the request to a controller, a board site, a stack position, a function and a device index. The block checks the routing. If the request is supported, it reads or writes an internal table: oscillator frequencies, or fixed voltage sensor readings for a main board and one add-on board. A few write functions also issue a shutdown or reboot request pulse to the rest of the system.

The whole transaction resolves on the clock edge that accepts the control write. A status register then reports completion, and it reports an error when the request was not supported. Software may write the status register to clear it. Reads return registered data one cycle after the read strobe.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: After reset the data, control and status registers read as zero. Main oscillators 0..5 hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. Add-on oscillators hold their parameter reset values.
- R2: The control register is at offset 0xA4. It reads back what was written, except that bit 31 (start) and bits 19:18 always read as zero. Field layout: bit 30 write (1) or read (0), bits 29:26 controller id, bits 25:20 function, bits 17:16 site, bits 15:12 position, bits 11:0 device.
- R3: A control write with bit 31 set makes the status register (offset 0xA8) read 1. It reads 3 if the transaction is unsupported. Status is software-writable in its low two bits.
- R4: A transaction is unsupported unless the controller id is 0, the position is 0, and the site is 0 (main) or 1 (add-on).
- R5: Function 1 on site 0 reads or writes main oscillator 0..5. A device index of 6 or more is an error.
- R6: Function 1 on site 1 reads or writes add-on oscillator 0..NUM_AUX_OSC-1. An index beyond that is an error.
- R7: Function 2 is read-only. On site 0 it returns 3300000 for device 0 only. On site 1 it returns the add-on voltage table entry for indices below NUM_AUX_VOLT. Anything else, including any write, is an error.
- R8: A write transaction with function 8 (shutdown) or 9 (reboot), site 0 and device 0 raises shutdown_req or reboot_req for exactly the one cycle after the control write. The same functions used as reads are errors.
- R9: Write transactions with function 7 or 11, site 0 and device 0 complete without error and change no table. Any other function value is an error.
- R10: A successful read copies its result into the data register (offset 0xA0). A failed read leaves the data register unchanged. A write transaction stores the current data register value.
- R11: A control write with bit 31 clear starts no transaction. Status, data and the oscillator tables keep their values.
- R12: Reading an unmapped offset returns zero. Read data appears on rdata one cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| shutdown_req | output | 1 | One-cycle shutdown request pulse |
| reboot_req | output | 1 | One-cycle reboot request pulse |

## Verification
The hardest situation to reach is a table write followed by a readback of the same entry. An oscillator write is only visible through a later read transaction that overwrites the data register. Any error on the way hides the stored value. The bench sweeps every site, function and small device index as reads on the reset tables. It then repeats the sweep as writes with a distinct operand per entry, and then repeats the reads. A bench-side model of each table predicts every status code and data value. Routing errors are swept over all non-zero controller ids and positions, with the data register preloaded so that an unchanged value is visible.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;
  localparam int WORD_W     = 32;
  localparam int MAIN_OSC_N = 6;
  localparam logic [31:0] MAIN_VOLT_UV = 32'd3300000;

  typedef struct packed {
    logic        start;
    logic        wnr;
    logic [3:0]  ctl_id;
    logic [5:0]  func;
    logic [1:0]  rsvd;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] dev;
  } cfg_cmd_t;

  localparam logic [5:0] FN_OSC      = 6'd1;
  localparam logic [5:0] FN_VOLT     = 6'd2;
  localparam logic [5:0] FN_VIDSEL   = 6'd7;
  localparam logic [5:0] FN_SHUT     = 6'd8;
  localparam logic [5:0] FN_REBOOT   = 6'd9;
  localparam logic [5:0] FN_DISPMODE = 6'd11;

  localparam logic [1:0] SITE_MAIN = 2'd0;
  localparam logic [1:0] SITE_AUX  = 2'd1;

  function automatic logic [31:0] main_osc_init(int idx);
    case (idx)
      0:       return 32'd50000000;
      1:       return 32'd23750000;
      default: return 32'd24000000;
    endcase
  endfunction
endpackage

// File: rtl/cfg_osc_bank.sv
module cfg_osc_bank
  import cfg_txn_pkg::*;
#(
  parameter int NUM_AUX_OSC = 2,
  parameter logic [NUM_AUX_OSC*32-1:0] AUX_OSC_INIT = {32'd27000000, 32'd25000000},
  localparam int DEPTH = MAIN_OSC_N + NUM_AUX_OSC,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wval,
  output logic [31:0]      rval
);
  function automatic logic [DEPTH*32-1:0] build_init();
    logic [DEPTH*32-1:0] v;
    v = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < MAIN_OSC_N) v[i*32 +: 32] = main_osc_init(i);
      else                v[i*32 +: 32] = AUX_OSC_INIT[(i-MAIN_OSC_N)*32 +: 32];
    end
    return v;
  endfunction

  localparam logic [DEPTH*32-1:0] INIT_VEC = build_init();

  logic [31:0] mem [DEPTH];
  logic        idx_ok;

  assign idx_ok = ({1'b0, idx} < (IDX_W+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT_VEC[i*32 +: 32];
    end else if (we && idx_ok) begin
      mem[idx] <= wval;
    end
  end

  always_comb begin
    rval = '0;
    if (idx_ok) rval = mem[idx];
  end
endmodule

// File: rtl/cfg_txn_decode.sv
module cfg_txn_decode
  import cfg_txn_pkg::*;
#(
  parameter int NUM_AUX_OSC  = 2,
  parameter int NUM_AUX_VOLT = 2,
  parameter logic [NUM_AUX_VOLT*32-1:0] AUX_VOLT_TABLE = {32'd1000000, 32'd900000},
  localparam int DEPTH = MAIN_OSC_N + NUM_AUX_OSC,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             wnr,
  input  logic [3:0]       ctl_id,
  input  logic [5:0]       func,
  input  logic [1:0]       site,
  input  logic [3:0]       pos,
  input  logic [11:0]      dev,
  input  logic [31:0]      osc_val,
  output logic [IDX_W-1:0] osc_idx,
  output logic             ok,
  output logic             osc_we,
  output logic             shut_hit,
  output logic             reboot_hit,
  output logic [31:0]      rd_val
);
  logic        route_ok, on_main, on_aux, main_dev0;
  logic        osc_range, volt_range;
  logic [11:0] flat_idx;
  logic [31:0] aux_volt;

  assign on_main   = (site == SITE_MAIN);
  assign on_aux    = (site == SITE_AUX);
  assign route_ok  = (ctl_id == 4'd0) && (pos == 4'd0) && (on_main || on_aux);
  assign main_dev0 = on_main && (dev == 12'd0);

  assign osc_range  = on_main ? (dev < 12'(MAIN_OSC_N)) : (dev < 12'(NUM_AUX_OSC));
  assign volt_range = on_main ? (dev == 12'd0) : (dev < 12'(NUM_AUX_VOLT));
  assign flat_idx   = on_main ? dev : dev + 12'(MAIN_OSC_N);
  assign osc_idx    = flat_idx[IDX_W-1:0];

  always_comb begin
    aux_volt = '0;
    for (int i = 0; i < NUM_AUX_VOLT; i++) begin
      if (dev == 12'(i)) aux_volt = AUX_VOLT_TABLE[i*32 +: 32];
    end
  end

  always_comb begin
    ok         = 1'b0;
    osc_we     = 1'b0;
    shut_hit   = 1'b0;
    reboot_hit = 1'b0;
    rd_val     = '0;
    case (func)
      FN_OSC: begin
        ok     = route_ok && osc_range;
        osc_we = ok && wnr;
        rd_val = osc_val;
      end
      FN_VOLT: begin
        ok     = route_ok && !wnr && volt_range;
        rd_val = on_main ? MAIN_VOLT_UV : aux_volt;
      end
      FN_VIDSEL, FN_DISPMODE: begin
        ok = route_ok && wnr && main_dev0;
      end
      FN_SHUT: begin
        ok       = route_ok && wnr && main_dev0;
        shut_hit = ok;
      end
      FN_REBOOT: begin
        ok         = route_ok && wnr && main_dev0;
        reboot_hit = ok;
      end
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
  import cfg_txn_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] DATA_OFF = 12'h0A0,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h0A4,
  parameter logic [ADDR_W-1:0] STAT_OFF = 12'h0A8,
  parameter int NUM_AUX_OSC  = 2,
  parameter int NUM_AUX_VOLT = 2,
  parameter logic [NUM_AUX_OSC*32-1:0]  AUX_OSC_INIT   = {32'd27000000, 32'd25000000},
  parameter logic [NUM_AUX_VOLT*32-1:0] AUX_VOLT_TABLE = {32'd1000000, 32'd900000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              shutdown_req,
  output logic              reboot_req
);
  localparam int DEPTH = MAIN_OSC_N + NUM_AUX_OSC;
  localparam int IDX_W = $clog2(DEPTH);

  cfg_cmd_t         cmd, ctrl_nxt;
  logic [31:0]      ctrl_q, data_q;
  logic [1:0]       stat_q;
  logic             launch;
  logic [IDX_W-1:0] osc_idx;
  logic             ok, osc_we, shut_hit, reboot_hit;
  logic [31:0]      rd_val, osc_val;

  assign cmd    = cfg_cmd_t'(wdata);
  assign launch = wr_en && (addr == CTRL_OFF) && cmd.start;

  always_comb begin
    ctrl_nxt       = cmd;
    ctrl_nxt.start = 1'b0;
    ctrl_nxt.rsvd  = 2'b00;
  end

  cfg_txn_decode #(
    .NUM_AUX_OSC   (NUM_AUX_OSC),
    .NUM_AUX_VOLT  (NUM_AUX_VOLT),
    .AUX_VOLT_TABLE(AUX_VOLT_TABLE)
  ) u_dec (
    .wnr       (cmd.wnr),
    .ctl_id    (cmd.ctl_id),
    .func      (cmd.func),
    .site      (cmd.site),
    .pos       (cmd.pos),
    .dev       (cmd.dev),
    .osc_val   (osc_val),
    .osc_idx   (osc_idx),
    .ok        (ok),
    .osc_we    (osc_we),
    .shut_hit  (shut_hit),
    .reboot_hit(reboot_hit),
    .rd_val    (rd_val)
  );

  cfg_osc_bank #(
    .NUM_AUX_OSC (NUM_AUX_OSC),
    .AUX_OSC_INIT(AUX_OSC_INIT)
  ) u_bank (
    .clk (clk),
    .rst (rst),
    .we  (launch && osc_we),
    .idx (osc_idx),
    .wval(data_q),
    .rval(osc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q       <= '0;
      data_q       <= '0;
      stat_q       <= '0;
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
    end else begin
      shutdown_req <= launch && shut_hit;
      reboot_req   <= launch && reboot_hit;
      if (wr_en) begin
        if (addr == DATA_OFF) data_q <= wdata;
        if (addr == STAT_OFF) stat_q <= wdata[1:0];
        if (addr == CTRL_OFF) begin
          ctrl_q <= ctrl_nxt;
          if (cmd.start) begin
            stat_q <= {~ok, 1'b1};
            if (ok && !cmd.wnr) data_q <= rd_val;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == DATA_OFF)      rdata <= data_q;
      else if (addr == CTRL_OFF) rdata <= ctrl_q;
      else if (addr == STAT_OFF) rdata <= {30'd0, stat_q};
      else                       rdata <= '0;
    end
  end
endmodule

// File: rtl/cfg_txn_checker.sv
module cfg_txn_checker #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h0A4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       data_q,
  input logic [1:0]        stat_q,
  input logic              shutdown_req,
  input logic              reboot_req
);
  logic ctl_wr;
  assign ctl_wr = wr_en && (addr == CTRL_OFF);

  a_r2_ctrl_masked: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (ctrl_q == ($past(wdata) & 32'h7FF3_FFFF)));

  a_r3_status_complete: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wdata[31]) |=> stat_q[0]);

  a_r8_shut_cause: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> $past(ctl_wr && wdata[31] && wdata[30]));

  a_r8_reboot_cause: assert property (@(posedge clk) disable iff (rst)
    reboot_req |-> $past(ctl_wr && wdata[31] && wdata[30]));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(shutdown_req && reboot_req));

  a_r10_fail_keeps_data: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wdata[31]) |=> (!stat_q[1] || data_q == $past(data_q)));

  a_r11_no_start_status: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !wdata[31]) |=> $stable(stat_q));
endmodule

bind cfg_txn_ctrl cfg_txn_checker #(.ADDR_W(ADDR_W), .CTRL_OFF(CTRL_OFF)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .ctrl_q(ctrl_q), .data_q(data_q), .stat_q(stat_q),
  .shutdown_req(shutdown_req), .reboot_req(reboot_req)
);

// File: tb/sim_cfg_txn_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_txn_ctrl;
  localparam int NA = 3;
  localparam int NV = 2;
  localparam logic [11:0] A_DATA = 12'h0A0, A_CTRL = 12'h0A4, A_STAT = 12'h0A8;

  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        shutdown_req, reboot_req;

  cfg_txn_ctrl #(
    .NUM_AUX_OSC(NA), .NUM_AUX_VOLT(NV),
    .AUX_OSC_INIT({32'd33000000, 32'd32000000, 32'd31000000}),
    .AUX_VOLT_TABLE({32'd1100000, 32'd900000})
  ) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mosc [6+NA];
  logic [31:0] mdata = '0;
  logic        cap_shut, cap_reb;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic done();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bwr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; cap_shut = shutdown_req; cap_reb = reboot_req;
  endtask

  task automatic brd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  function automatic bit exp_ok(bit wnr, int dcc, int fn, int site, int pos, int dev);
    if (dcc != 0 || pos != 0 || site > 1) return 0;
    case (fn)
      1: return (site == 0) ? (dev < 6) : (dev < NA);
      2: return !wnr && ((site == 0) ? (dev == 0) : (dev < NV));
      7, 8, 9, 11: return wnr && site == 0 && dev == 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_val(int fn, int site, int dev);
    if (fn == 1) return mosc[(site == 0) ? dev : 6 + dev];
    if (site == 0) return 32'd3300000;
    return (dev == 0) ? 32'd900000 : 32'd1100000;
  endfunction

  task automatic txn(string req, bit wnr, int dcc, int fn, int site, int pos, int dev,
                     logic [31:0] opnd);
    logic [31:0] r;
    bit ok;
    ok = exp_ok(wnr, dcc, fn, site, pos, dev);
    if (wnr) begin bwr(A_DATA, opnd); mdata = opnd; end
    bwr(A_CTRL, {1'b1, wnr, 4'(dcc), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)});
    chk({req, " R8 shutdown pulse"}, {31'd0, cap_shut}, {31'd0, ok && wnr && fn == 8});
    chk({req, " R8 reboot pulse"}, {31'd0, cap_reb}, {31'd0, ok && wnr && fn == 9});
    if (ok && !wnr) mdata = exp_val(fn, site, dev);
    if (ok && wnr && fn == 1) mosc[(site == 0) ? dev : 6 + dev] = mdata;
    brd(A_STAT, r);
    chk({req, " R3 status"}, r, ok ? 32'd1 : 32'd3);
    chk({req, " R8 pulse ends"}, {30'd0, shutdown_req, reboot_req}, 32'd0);
    brd(A_DATA, r);
    chk({req, " R10 data"}, r, mdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done();
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 6; i++) mosc[i] = (i == 0) ? 32'd50000000 : (i == 1) ? 32'd23750000 : 32'd24000000;
    for (int i = 0; i < NA; i++) mosc[6+i] = 32'd31000000 + 32'(i) * 32'd1000000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    brd(A_DATA, r); chk("R1 data reset", r, 0);
    brd(A_CTRL, r); chk("R1 ctrl reset", r, 0);
    brd(A_STAT, r); chk("R1 status reset", r, 0);
    chk("R1 no pulses", {30'd0, shutdown_req, reboot_req}, 0);
    // R1 R5 R6 R7 R9: read sweep on reset tables
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 13; f++)
        for (int d = 0; d < 8; d++) txn("R4 R5 R6 R7 R9 read", 1'b0, 0, f, s, 0, d, 0);
    // write sweep with distinct operands
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 13; f++)
        for (int d = 0; d < 8; d++)
          txn("R5 R6 R7 R8 R9 write", 1'b1, 0, f, s, 0, d,
              32'hA000_0000 | 32'(f << 16) | 32'(s << 8) | 32'(d));
    // read back written oscillators
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 8; d++) txn("R5 R6 readback", 1'b0, 0, 1, s, 0, d, 0);
    // R4: routing errors keep preloaded data
    for (int k = 1; k < 16; k++) begin
      bwr(A_DATA, 32'h5A5A_0000 | 32'(k)); mdata = 32'h5A5A_0000 | 32'(k);
      txn("R4 controller id", 1'b0, k, 1, 0, 0, 0, 0);
      txn("R4 position", 1'b0, 0, 1, 0, k, 0, 0);
    end
    // R2: control readback masking
    bwr(A_CTRL, 32'hFFFF_FFFF);
    brd(A_CTRL, r); chk("R2 ctrl mask", r, 32'h7FF3_FFFF);
    bwr(A_CTRL, 32'h4015_2ABC);
    brd(A_CTRL, r); chk("R2 ctrl readback", r, 32'h4011_2ABC);
    // R3: status writable
    bwr(A_STAT, 32'hFFFF_FFFE);
    brd(A_STAT, r); chk("R3 status write", r, 32'd2);
    bwr(A_STAT, 32'd0);
    brd(A_STAT, r); chk("R3 status clear", r, 32'd0);
    // R11: control write without start
    bwr(A_DATA, 32'h1234_5678);
    bwr(A_CTRL, 32'h4010_0000);
    chk("R11 no pulse", {30'd0, cap_shut, cap_reb}, 0);
    brd(A_STAT, r); chk("R11 status kept", r, 0);
    brd(A_DATA, r); chk("R11 data kept", r, 32'h1234_5678);
    mdata = 32'h1234_5678;
    txn("R11 table kept", 1'b0, 0, 1, 0, 0, 0, 0);
    // R12: unmapped offsets and read latency
    brd(12'h000, r); chk("R12 unmapped 0x000", r, 0);
    brd(12'h0AC, r); chk("R12 unmapped 0x0AC", r, 0);
    @(negedge clk); rd_en = 1'b1; addr = A_DATA;
    chk("R12 not yet updated", rdata, 0);
    @(negedge clk); rd_en = 1'b0;
    chk("R12 one-cycle latency", rdata, mdata);
    done();
  end
endmodule